// File: doc/BRIEF.md
# ADC Result Buffering Sequencer

This block sits between an analog-to-digital converter core and a set of eight conversion result registers. The converter signals each finished conversion with a one-cycle strobe, carrying the channel it converted and the result data. The block decides which result register receives the value and writes it there. It raises a one-cycle conversion-end interrupt and gives combinational read access to every register.

A control register holds five settings: the buffering mode, the selected input, the resolution, the serial or parallel variant, and the conversion-start period. In single-buffer mode every result lands in the register with the same index as its channel, and each result raises an interrupt. In four-buffer mode the selected input is converted repeatedly. Its results fill the four registers of the bank that holds that input, in order, and an interrupt is raised only when the bank is full. A read-pending flag is set with each interrupt and stays set until software reads a register of the completed group. A prescaler issues conversion-start requests at the programmed period. The parallel variant issues them four times as often.

Top module: `adc_result_sequencer`

## Requirements
- R1: After reset all eight result registers read 0, and irq and pending are 0.
- R2: With cfg_quad=0 (single-buffer mode), a strobe on conv_done writes conv_data to register conv_ch. irq is high for exactly the one cycle after the strobe cycle.
- R3: With cfg_quad=1 (four-buffer mode), conv_ch is ignored. Results go to registers base+0, base+1, base+2 and base+3 in arrival order, where base is 0 for selected inputs 0 to 3 and 4 for selected inputs 4 to 7. Registers outside that bank keep their values.
- R4: In four-buffer mode irq pulses only in the cycle after the fourth result of a bank fill. The first three results raise no interrupt.
- R5: A control-register write that changes the mode or the selected input restarts the bank fill at slot 0.
- R6: With cfg_narrow=1 (8-bit resolution), a stored result keeps conv_data[9:2], and bits [1:0] read as 0.
- R7: pending rises together with irq. A read with rd_en=1 of a register in the completed group clears it: the register just written in single-buffer mode, or the whole bank in four-buffer mode. A read of a register outside that group leaves pending set.
- R8: When a completion and a clearing read fall in the same cycle, the completion wins. pending stays 1 and now covers the new group.
- R9: start_req pulses once every cfg_period cycles in the serial variant (cfg_parallel=0) and once every cfg_period/4 cycles in the parallel variant (cfg_parallel=1). The count restarts on every control-register write. cfg_period must be at least 8.
- R10: adc_ch always shows the selected input from the last control-register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_quad | input | 1 | 0 = single-buffer mode, 1 = four-buffer mode |
| cfg_sel | input | 3 | Selected input for four-buffer mode |
| cfg_narrow | input | 1 | 1 = 8-bit resolution |
| cfg_parallel | input | 1 | 1 = parallel variant (start period divided by four) |
| cfg_period | input | 16 | Conversion-start period in clock cycles |
| start_req | output | 1 | Conversion-start request pulse |
| adc_ch | output | 3 | Input the converter should sample in four-buffer mode |
| conv_done | input | 1 | Conversion-complete strobe from the converter |
| conv_ch | input | 3 | Channel of the completed conversion |
| conv_data | input | 10 | Conversion result |
| rd_en | input | 1 | Read strobe; clears pending on a read of the completed group |
| rd_addr | input | 3 | Result register index to read |
| rd_data | output | 10 | Result register contents |
| irq | output | 1 | Conversion-end interrupt pulse |
| pending | output | 1 | Read-pending flag |

## Verification
Two functions can land in the same cycle: a completion that sets the read-pending flag, and a software read that clears it. The bench provokes this by driving a single-buffer strobe on channel 5 in the same cycle as a read of register 2, which is the group the flag currently covers. It then expects pending to stay 1. A later read of register 2 must leave the flag set, and a read of register 5 must clear it, which shows that the flag moved over to the new group.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   typedef enum logic {
      MODE_SINGLE = 1'b0,
      MODE_QUAD   = 1'b1
   } buf_mode_e;

   // mask with one bit per result register covering a contiguous group
   function automatic logic [63:0] group_mask(input int unsigned first,
                                              input int unsigned count);
      logic [63:0] m;
      m = '0;
      for (int unsigned i = 0; i < 64; i++) begin
         if (i >= first && i < first + count) m[i] = 1'b1;
      end
      return m;
   endfunction

endpackage

// File: rtl/adc_seq_trigger.sv
module adc_seq_trigger #(
   parameter int PERIOD_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                restart,
   input  logic                parallel_i,
   input  logic [PERIOD_W-1:0] period_i,
   output logic                start_req
);

   logic [PERIOD_W-1:0] interval;
   logic [PERIOD_W-1:0] count_q;
   logic                at_end;

   always_comb begin
      if (parallel_i) interval = {2'b00, period_i[PERIOD_W-1:2]};
      else            interval = period_i;
   end

   assign at_end    = (count_q >= interval - 1'b1);
   assign start_req = at_end;

   always_ff @(posedge clk) begin
      if (!rst_n)       count_q <= '0;
      else if (restart) count_q <= '0;
      else if (at_end)  count_q <= '0;
      else              count_q <= count_q + 1'b1;
   end

   // R9
   start_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_req && !restart && period_i >= PERIOD_W'(8)) |=> !start_req);

endmodule

// File: rtl/adc_seq_writer.sv
module adc_seq_writer #(
   parameter int NUM_CH   = 8,
   parameter int DEPTH    = 4,
   parameter int RES_W    = 10,
   parameter int NARROW_W = 8,
   localparam int CH_W    = $clog2(NUM_CH),
   localparam int SLOT_W  = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              quad_i,
   input  logic [CH_W-1:0]   sel_i,
   input  logic              narrow_i,
   input  logic              cfg_change,
   input  logic              conv_done,
   input  logic [CH_W-1:0]   conv_ch,
   input  logic [RES_W-1:0]  conv_data,
   output logic              wr_en,
   output logic [CH_W-1:0]   wr_addr,
   output logic [RES_W-1:0]  wr_data,
   output logic              complete,
   output logic [NUM_CH-1:0] complete_mask,
   output logic              irq
);
   import adc_seq_pkg::*;

   logic [SLOT_W-1:0] slot_q;
   logic [CH_W-1:0]   bank_base;
   logic              last_slot;

   assign bank_base = {sel_i[CH_W-1:SLOT_W], {SLOT_W{1'b0}}};
   assign last_slot = (slot_q == SLOT_W'(DEPTH - 1));

   always_comb begin
      wr_en = conv_done;
      if (quad_i) wr_addr = bank_base | CH_W'(slot_q);
      else        wr_addr = conv_ch;
      complete = conv_done && (!quad_i || last_slot);
      if (quad_i) complete_mask = NUM_CH'(group_mask(int'(bank_base), DEPTH));
      else        complete_mask = NUM_CH'(group_mask(int'(conv_ch), 1));
   end

   generate
      if (NARROW_W < RES_W) begin : g_trim
         always_comb begin
            if (narrow_i)
               wr_data = {conv_data[RES_W-1:RES_W-NARROW_W], {(RES_W-NARROW_W){1'b0}}};
            else
               wr_data = conv_data;
         end
      end else begin : g_full
         assign wr_data = conv_data;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slot_q <= '0;
         irq    <= 1'b0;
      end else begin
         irq <= complete;
         if (cfg_change)            slot_q <= '0;
         else if (conv_done && quad_i) slot_q <= slot_q + 1'b1;
      end
   end

   // R2
   irq_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(conv_done));

   // R4
   quad_irq_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && $past(quad_i)) |-> $past(slot_q) == SLOT_W'(DEPTH - 1));

   // R5
   slot_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_change |=> slot_q == '0);

endmodule

// File: rtl/adc_seq_bank.sv
module adc_seq_bank #(
   parameter int NUM_CH = 8,
   parameter int RES_W  = 10,
   localparam int CH_W  = $clog2(NUM_CH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CH_W-1:0]  wr_addr,
   input  logic [RES_W-1:0] wr_data,
   input  logic [CH_W-1:0]  rd_addr,
   output logic [RES_W-1:0] rd_data
);

   logic [RES_W-1:0] result_q [NUM_CH];

   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n)
               result_q[i] <= '0;
            else if (wr_en && wr_addr == CH_W'(i))
               result_q[i] <= wr_data;
         end
      end
   endgenerate

   assign rd_data = result_q[rd_addr];

endmodule

// File: rtl/adc_seq_pending.sv
module adc_seq_pending #(
   parameter int NUM_CH = 8,
   localparam int CH_W  = $clog2(NUM_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_i,
   input  logic [NUM_CH-1:0] set_mask,
   input  logic              rd_en,
   input  logic [CH_W-1:0]   rd_addr,
   output logic              pending
);

   logic [NUM_CH-1:0] mask_q;
   logic              clear;

   assign clear = rd_en && mask_q[rd_addr];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pending <= 1'b0;
         mask_q  <= '0;
      end else if (set_i) begin
         pending <= 1'b1;
         mask_q  <= set_mask;
      end else if (clear) begin
         pending <= 1'b0;
         mask_q  <= '0;
      end
   end

   // R8
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i && clear) |=> pending);

endmodule

// File: rtl/adc_result_sequencer.sv
module adc_result_sequencer #(
   parameter int NUM_CH       = 8,
   parameter int DEPTH        = 4,
   parameter int RES_W        = 10,
   parameter int NARROW_W     = 8,
   parameter int PERIOD_W     = 16,
   parameter int RESET_PERIOD = 64,
   localparam int CH_W        = $clog2(NUM_CH)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_we,
   input  logic                cfg_quad,
   input  logic [CH_W-1:0]     cfg_sel,
   input  logic                cfg_narrow,
   input  logic                cfg_parallel,
   input  logic [PERIOD_W-1:0] cfg_period,
   output logic                start_req,
   output logic [CH_W-1:0]     adc_ch,
   input  logic                conv_done,
   input  logic [CH_W-1:0]     conv_ch,
   input  logic [RES_W-1:0]    conv_data,
   input  logic                rd_en,
   input  logic [CH_W-1:0]     rd_addr,
   output logic [RES_W-1:0]    rd_data,
   output logic                irq,
   output logic                pending
);
   import adc_seq_pkg::*;

   generate
      if (NUM_CH % DEPTH != 0) begin : g_bad_depth
         $error("NUM_CH must be a multiple of DEPTH");
      end
      if ((1 << $clog2(DEPTH)) != DEPTH || DEPTH < 2) begin : g_bad_pow
         $error("DEPTH must be a power of two, at least 2");
      end
      if (NARROW_W > RES_W || NARROW_W < 1) begin : g_bad_narrow
         $error("NARROW_W must lie in 1..RES_W");
      end
      if (PERIOD_W < 4 || RESET_PERIOD < 8 || RESET_PERIOD >= (1 << PERIOD_W)) begin : g_bad_period
         $error("RESET_PERIOD must be at least 8 and fit PERIOD_W");
      end
   endgenerate

   buf_mode_e           mode_q;
   logic [CH_W-1:0]     sel_q;
   logic                narrow_q;
   logic                parallel_q;
   logic [PERIOD_W-1:0] period_q;
   logic                cfg_change;

   assign cfg_change = cfg_we &&
                       ((buf_mode_e'(cfg_quad) != mode_q) || (cfg_sel != sel_q));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q     <= MODE_SINGLE;
         sel_q      <= '0;
         narrow_q   <= 1'b0;
         parallel_q <= 1'b0;
         period_q   <= PERIOD_W'(RESET_PERIOD);
      end else if (cfg_we) begin
         mode_q     <= buf_mode_e'(cfg_quad);
         sel_q      <= cfg_sel;
         narrow_q   <= cfg_narrow;
         parallel_q <= cfg_parallel;
         period_q   <= cfg_period;
      end
   end

   assign adc_ch = sel_q;

   logic              wr_en;
   logic [CH_W-1:0]   wr_addr;
   logic [RES_W-1:0]  wr_data;
   logic              complete;
   logic [NUM_CH-1:0] complete_mask;

   adc_seq_trigger #(.PERIOD_W(PERIOD_W)) u_trigger (
      .clk        (clk),
      .rst_n      (rst_n),
      .restart    (cfg_we),
      .parallel_i (parallel_q),
      .period_i   (period_q),
      .start_req  (start_req)
   );

   adc_seq_writer #(
      .NUM_CH   (NUM_CH),
      .DEPTH    (DEPTH),
      .RES_W    (RES_W),
      .NARROW_W (NARROW_W)
   ) u_writer (
      .clk           (clk),
      .rst_n         (rst_n),
      .quad_i        (mode_q == MODE_QUAD),
      .sel_i         (sel_q),
      .narrow_i      (narrow_q),
      .cfg_change    (cfg_change),
      .conv_done     (conv_done),
      .conv_ch       (conv_ch),
      .conv_data     (conv_data),
      .wr_en         (wr_en),
      .wr_addr       (wr_addr),
      .wr_data       (wr_data),
      .complete      (complete),
      .complete_mask (complete_mask),
      .irq           (irq)
   );

   adc_seq_bank #(.NUM_CH(NUM_CH), .RES_W(RES_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (rd_addr),
      .rd_data (rd_data)
   );

   adc_seq_pending #(.NUM_CH(NUM_CH)) u_pending (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_i    (complete),
      .set_mask (complete_mask),
      .rd_en    (rd_en),
      .rd_addr  (rd_addr),
      .pending  (pending)
   );

   // R7
   pend_with_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> pending);

   // R6
   narrow_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr_en && narrow_q) |-> u_bank.result_q[$past(wr_addr)][RES_W-NARROW_W-1:0] == '0);

   // R10
   sel_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cfg_we) |-> adc_ch == $past(cfg_sel));

endmodule

// File: tb/adc_result_sequencer_test.sv
`timescale 1ns/100ps
module adc_result_sequencer_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0, cfg_quad = 1'b0, cfg_narrow = 1'b0, cfg_parallel = 1'b0;
   logic [2:0]  cfg_sel = '0;
   logic [15:0] cfg_period = 16'd64;
   logic        start_req;
   logic [2:0]  adc_ch;
   logic        conv_done = 1'b0;
   logic [2:0]  conv_ch = '0;
   logic [9:0]  conv_data = '0;
   logic        rd_en = 1'b0;
   logic [2:0]  rd_addr = '0;
   logic [9:0]  rd_data;
   logic        irq, pending;

   int checks = 0;
   int errors = 0;
   bit done_flag = 0;
   bit prev_done = 0;
   bit exp_q[$];

   always #2.5 clk = ~clk;

   adc_result_sequencer uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_quad(cfg_quad),
      .cfg_sel(cfg_sel), .cfg_narrow(cfg_narrow), .cfg_parallel(cfg_parallel),
      .cfg_period(cfg_period), .start_req(start_req), .adc_ch(adc_ch),
      .conv_done(conv_done), .conv_ch(conv_ch), .conv_data(conv_data),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
      .irq(irq), .pending(pending)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // monitor: pops the expected interrupt for each strobe one cycle later
   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_done) begin
            if (exp_q.size() == 0) check(0, "R2 scoreboard underflow", 1, 0);
            else begin
               bit e;
               e = exp_q.pop_front();
               check(irq == e, "R2/R4 irq after strobe", irq, e);
            end
         end else if (irq) check(0, "R2/R4 irq without strobe", 1, 0);
      end
      prev_done = conv_done;
   end

   task automatic cfg(input bit q, input logic [2:0] s, input bit n, input bit p,
                      input logic [15:0] per);
      @(posedge clk); #1;
      cfg_we = 1; cfg_quad = q; cfg_sel = s; cfg_narrow = n; cfg_parallel = p;
      cfg_period = per;
      @(posedge clk); #1;
      cfg_we = 0;
   endtask

   task automatic strobe(input logic [2:0] ch, input logic [9:0] d, input bit exp_irq);
      @(posedge clk); #1;
      conv_done = 1; conv_ch = ch; conv_data = d;
      exp_q.push_back(exp_irq);
      @(posedge clk); #1;
      conv_done = 0;
   endtask

   task automatic rd(input logic [2:0] a, input bit en, input int exp, input string tag);
      @(posedge clk); #1;
      rd_addr = a; rd_en = en;
      #1 check(rd_data == exp, tag, rd_data, exp);
      @(posedge clk); #1;
      rd_en = 0;
   endtask

   task automatic pend_chk(input bit exp, input string tag);
      #1 check(pending == exp, tag, pending, exp);
   endtask

   task automatic gap_chk(input int exp, input string tag);
      int n;
      @(negedge clk);
      while (!start_req) @(negedge clk);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!start_req);
      check(n == exp, tag, n, exp);
   endtask

   initial begin
      #100000;
      if (!done_flag) begin
         check(0, "watchdog expired", 0, 1);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      // R1 reset state
      for (int i = 0; i < 8; i++) rd(3'(i), 0, 0, "R1 reset register");
      check(irq == 0, "R1 irq reset", irq, 0);
      pend_chk(0, "R1 pending reset");

      // R2 single-buffer mapping, R7 pending clear rules
      cfg(0, 0, 0, 0, 16'd20);
      strobe(3, 10'h155, 1);
      rd(3, 0, 10'h155, "R2 single ch3");
      pend_chk(1, "R7 pending after irq");
      rd(2, 1, 0, "R7 read outside group");
      pend_chk(1, "R7 pending kept by other read");
      rd(3, 1, 10'h155, "R7 read group");
      pend_chk(0, "R7 pending cleared");
      strobe(7, 10'h3AA, 1);
      rd(7, 1, 10'h3AA, "R2 single ch7");

      // R3/R4 four-buffer, upper bank, conv_ch ignored
      cfg(1, 5, 0, 0, 16'd20);
      check(adc_ch == 5, "R10 adc_ch follows sel", adc_ch, 5);
      strobe(0, 10'h011, 0);
      strobe(0, 10'h022, 0);
      strobe(1, 10'h033, 0);
      strobe(2, 10'h044, 1);
      rd(4, 0, 10'h011, "R3 upper slot0");
      rd(5, 0, 10'h022, "R3 upper slot1");
      rd(6, 0, 10'h033, "R3 upper slot2");
      rd(7, 0, 10'h044, "R3 upper slot3");
      rd(0, 0, 0, "R3 lower bank untouched");
      rd(3, 0, 10'h155, "R3 lower reg3 untouched");
      rd(1, 1, 0, "R7 read outside bank");
      pend_chk(1, "R7 quad pending kept");
      rd(6, 1, 10'h033, "R7 read bank");
      pend_chk(0, "R7 quad pending cleared");

      // R3 lower bank
      cfg(1, 2, 0, 0, 16'd20);
      strobe(7, 10'h101, 0);
      strobe(7, 10'h102, 0);
      strobe(7, 10'h103, 0);
      strobe(7, 10'h104, 1);
      for (int i = 0; i < 4; i++) rd(3'(i), 0, 10'h101 + i, "R3 lower slots");
      rd(7, 0, 10'h044, "R3 upper bank untouched");

      // R5 slot restart on selection change
      cfg(1, 6, 0, 0, 16'd20);
      strobe(0, 10'h201, 0);
      strobe(0, 10'h202, 0);
      cfg(1, 7, 0, 0, 16'd20);
      check(adc_ch == 7, "R10 adc_ch new sel", adc_ch, 7);
      strobe(0, 10'h2A0, 0);
      strobe(0, 10'h2A1, 0);
      strobe(0, 10'h2A2, 0);
      strobe(0, 10'h2A3, 1);
      rd(4, 0, 10'h2A0, "R5 restart slot0");
      rd(7, 1, 10'h2A3, "R5 restart slot3");

      // R6 narrow resolution
      cfg(0, 0, 1, 0, 16'd20);
      strobe(1, 10'h3FF, 1);
      rd(1, 1, 10'h3FC, "R6 narrow result");
      strobe(2, 10'h2B7, 1);
      rd(2, 0, 10'h2B4, "R6 narrow result 2");

      // R8 completion and clearing read in one cycle
      @(posedge clk); #1;
      conv_done = 1; conv_ch = 5; conv_data = 10'h0F0;
      rd_en = 1; rd_addr = 2;
      exp_q.push_back(1);
      @(posedge clk); #1;
      conv_done = 0; rd_en = 0;
      pend_chk(1, "R8 set wins");
      rd(2, 1, 10'h2B4, "R8 old group read");
      pend_chk(1, "R8 moved to new group");
      rd(5, 1, 10'h0F0, "R8 new group read");
      pend_chk(0, "R8 cleared by new group");

      // R9 start-request spacing
      cfg(0, 0, 0, 0, 16'd20);
      gap_chk(20, "R9 serial period");
      gap_chk(20, "R9 serial period again");
      cfg(0, 0, 0, 1, 16'd20);
      gap_chk(5, "R9 parallel period");
      cfg(0, 0, 0, 0, 16'd36);
      gap_chk(36, "R9 serial period 36");

      repeat (3) @(posedge clk);
      check(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);
      done_flag = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule